// File: doc/BRIEF.md
# Interrupt Source Lifecycle Store

This block holds the lifecycle state of a bank of interrupt sources, one small tracker per source. Each source is in one of four states: idle, pending, active, or active-and-pending. Each source can be set up as level-sensitive or edge-triggered, and optionally as a source with no active state. The block samples each raw source line. It takes acknowledge and deactivate strobes from the CPU-side logic, and it takes software set and clear strobes for the pending state. It presents a pending vector and an active vector to a priority arbiter that sits outside this block.

A level source is pending while its line is high or while a software-set request is held. An edge source latches a pending flag on each rising edge of its line. An acknowledge moves a pending source to active. A level source whose line is still high is therefore active-and-pending right after the acknowledge. A deactivate ends the active phase, and any pending state left over is presented again.

The state is encoded per source as two bits, {active, pending}: 00 idle, 01 pending, 10 active, 11 active-and-pending. The acknowledge and deactivate strobes each carry a binary source index. Arbitration, routing and register decoding are left to neighbouring logic.

Top module: `irq_pend_store`

## Requirements
- R1: After reset every bit of `pend_out` and `act_out` is 0.
- R2: A level source (`src_is_edge`=0) whose line is high at a clock edge shows `pend_out`=1 after that edge, if it is enabled.
- R3: For a level source, an accepted acknowledge while the line is high gives active=1 and pending=1. When the line then goes low, pending drops to 0 and active stays 1.
- R4: For an edge source (`src_is_edge`=1), a 0-to-1 change of the line sets pending. An accepted acknowledge then gives active=1 and pending=0.
- R5: For an edge source, a rising edge while the source is active gives active-and-pending. A second edge while the source is already pending is absorbed, so a single acknowledge leaves pending=0.
- R6: A deactivate (`deact_valid`=1, `deact_id`=index) to an active source clears active. An active-and-pending source becomes pending, and an active source becomes idle.
- R7: A source with `src_no_act`=1 never becomes active. Its acknowledge returns it straight to idle.
- R8: A disabled source (`src_enable`=0) reports `pend_out`=0 but keeps its stored pending state. An acknowledge to it is ignored.
- R9: `sw_set` sets the pending state and `sw_clr` clears it. When both arrive in the same cycle, clear wins. In level mode these strobes act only on the software-held part of pending, and an accepted acknowledge clears that part.
- R10: An acknowledge counts only for an enabled source that is pending and not active. A deactivate counts only for an active source. At most one source takes an acknowledge per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_line | input | NUM_SRC | Raw interrupt lines |
| src_enable | input | NUM_SRC | Per-source enable |
| src_is_edge | input | NUM_SRC | 1 = edge-triggered, 0 = level-sensitive |
| src_no_act | input | NUM_SRC | 1 = source has no active state |
| sw_set | input | NUM_SRC | Software set-pending strobes |
| sw_clr | input | NUM_SRC | Software clear-pending strobes |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | ID_W | Index of the acknowledged source |
| deact_valid | input | 1 | Deactivate strobe |
| deact_id | input | ID_W | Index of the deactivated source |
| pend_out | output | NUM_SRC | Pending, masked by enable, to the arbiter |
| act_out | output | NUM_SRC | Active state per source |

## Verification
The assertions check the following on every cycle:
- Pending follows the line for level sources and is set by rising edges for edge sources.
- An accepted acknowledge activates the source, or returns it to idle when it has no active state.
- A deactivate clears active, and deactivates to sources that are not active have no effect.
- Clear wins over set on edge sources.
- An acknowledge to a disabled source is ignored, and at most one acknowledge is taken per cycle.

Only the bench scenarios can show the full state sequences:
- A level source passing through active-and-pending to active as its line falls.
- An edge source returning to pending after deactivation.
- An absorbed second edge.
- Pending state kept across a disable.
- Software pending in level mode being consumed by the acknowledge.

// File: rtl/irq_state_pkg.sv
package irq_state_pkg;

  // Lifecycle code: bit 1 = active, bit 0 = pending
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PEND = 2'b01,
    ST_ACT  = 2'b10,
    ST_BOTH = 2'b11
  } irq_state_e;

  typedef struct packed {
    logic act;
    logic pend;
    logic sw;     // software-held pending, level mode only
  } trk_bits_t;

  function automatic irq_state_e f_code(input trk_bits_t b);
    return irq_state_e'({b.act, b.pend});
  endfunction

  // Whether an acknowledge strobe is taken by the source
  function automatic logic f_ack_ok(input trk_bits_t cur, input logic hit,
                                    input logic enable);
    return hit & enable & cur.pend & ~cur.act;
  endfunction

  // Whether a deactivate strobe is taken by the source
  function automatic logic f_deact_ok(input trk_bits_t cur, input logic hit);
    return hit & cur.act;
  endfunction

  // One step of the per-source lifecycle
  function automatic trk_bits_t f_step(
    input trk_bits_t cur,
    input logic      is_edge,
    input logic      no_act,
    input logic      line,
    input logic      rise,
    input logic      ack_ok,
    input logic      deact_ok,
    input logic      set_p,
    input logic      clr_p
  );
    trk_bits_t nxt;
    nxt = cur;
    if (deact_ok)           nxt.act = 1'b0;
    if (ack_ok && !no_act)  nxt.act = 1'b1;
    if (is_edge) begin
      if (ack_ok) nxt.pend = 1'b0;
      if (rise)   nxt.pend = 1'b1;
      if (set_p)  nxt.pend = 1'b1;
      if (clr_p)  nxt.pend = 1'b0;
      nxt.sw = 1'b0;
    end else begin
      if (ack_ok) nxt.sw = 1'b0;
      if (set_p)  nxt.sw = 1'b1;
      if (clr_p)  nxt.sw = 1'b0;
      nxt.pend = line | nxt.sw;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/irq_strobe_decode.sv
module irq_strobe_decode #(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = 3
) (
  input  logic               valid,
  input  logic [ID_W-1:0]    id,
  output logic [NUM_SRC-1:0] hit
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
    assign hit[i] = valid && (id == ID_W'(i));
  end

endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  output logic rise
);

  logic line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line;
  end

  assign rise = line & ~line_q;

endmodule

// File: rtl/irq_src_tracker.sv
module irq_src_tracker
  import irq_state_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line,
  input  logic       enable,
  input  logic       is_edge,
  input  logic       no_act,
  input  logic       ack_hit,
  input  logic       deact_hit,
  input  logic       set_pend,
  input  logic       clr_pend,
  output logic       pend_out,
  output logic       act_out,
  output logic       edge_evt,
  output logic       ack_taken,
  output irq_state_e state
);

  trk_bits_t cur_q;
  trk_bits_t nxt;
  logic      deact_taken;

  irq_edge_detect u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .line  (line),
    .rise  (edge_evt)
  );

  assign ack_taken   = f_ack_ok(cur_q, ack_hit, enable);
  assign deact_taken = f_deact_ok(cur_q, deact_hit);

  always_comb begin
    nxt = f_step(cur_q, is_edge, no_act, line, edge_evt, ack_taken,
                 deact_taken, set_pend, clr_pend);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  assign pend_out = cur_q.pend & enable;
  assign act_out  = cur_q.act;
  assign state    = f_code(cur_q);

endmodule

// File: rtl/irq_pend_store.sv
module irq_pend_store
  import irq_state_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_line,
  input  logic [NUM_SRC-1:0] src_enable,
  input  logic [NUM_SRC-1:0] src_is_edge,
  input  logic [NUM_SRC-1:0] src_no_act,
  input  logic [NUM_SRC-1:0] sw_set,
  input  logic [NUM_SRC-1:0] sw_clr,
  input  logic               ack_valid,
  input  logic [ID_W-1:0]    ack_id,
  input  logic               deact_valid,
  input  logic [ID_W-1:0]    deact_id,
  output logic [NUM_SRC-1:0] pend_out,
  output logic [NUM_SRC-1:0] act_out
);

  // Named internal events, used by the bound checker
  logic [NUM_SRC-1:0] ack_hit;
  logic [NUM_SRC-1:0] deact_hit;
  logic [NUM_SRC-1:0] edge_evt;
  logic [NUM_SRC-1:0] ack_taken;
  irq_state_e         src_state [NUM_SRC];

  irq_strobe_decode #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_ack_dec (
    .valid (ack_valid),
    .id    (ack_id),
    .hit   (ack_hit)
  );

  irq_strobe_decode #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_deact_dec (
    .valid (deact_valid),
    .id    (deact_id),
    .hit   (deact_hit)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_src_tracker u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .line      (src_line[i]),
      .enable    (src_enable[i]),
      .is_edge   (src_is_edge[i]),
      .no_act    (src_no_act[i]),
      .ack_hit   (ack_hit[i]),
      .deact_hit (deact_hit[i]),
      .set_pend  (sw_set[i]),
      .clr_pend  (sw_clr[i]),
      .pend_out  (pend_out[i]),
      .act_out   (act_out[i]),
      .edge_evt  (edge_evt[i]),
      .ack_taken (ack_taken[i]),
      .state     (src_state[i])
    );
  end

endmodule

// File: rtl/irq_pend_store_chk.sv
module irq_pend_store_chk
  import irq_state_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_line,
  input logic [NUM_SRC-1:0] src_enable,
  input logic [NUM_SRC-1:0] src_is_edge,
  input logic [NUM_SRC-1:0] src_no_act,
  input logic [NUM_SRC-1:0] sw_set,
  input logic [NUM_SRC-1:0] sw_clr,
  input logic               ack_valid,
  input logic [ID_W-1:0]    ack_id,
  input logic               deact_valid,
  input logic [ID_W-1:0]    deact_id,
  input logic [NUM_SRC-1:0] pend_out,
  input logic [NUM_SRC-1:0] act_out,
  input logic [NUM_SRC-1:0] edge_evt,
  input logic [NUM_SRC-1:0] ack_taken,
  input irq_state_e         src_state [NUM_SRC]
);

  AST_ONE_ACK_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_taken)); // R10

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    AST_LEVEL_LINE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_is_edge[i] && src_line[i] && src_enable[i])
      |=> (pend_out[i] || !src_enable[i])); // R2

    AST_LEVEL_ACK_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_taken[i] && !src_is_edge[i] && !src_no_act[i] && src_line[i])
      |=> (act_out[i] && src_state[i] == ST_BOTH)); // R3

    AST_EDGE_ACK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_taken[i] && src_is_edge[i] && !edge_evt[i] && !sw_set[i])
      |=> !src_state[i][0]); // R4

    AST_EDGE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (src_is_edge[i] && edge_evt[i] && !sw_clr[i])
      |=> src_state[i][0]); // R5

    AST_DEACT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (deact_valid && deact_id == ID_W'(i) && act_out[i])
      |=> !act_out[i]); // R6

    AST_NO_ACT_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (src_no_act[i] && !act_out[i]) |=> !act_out[i]); // R7

    AST_DISABLED_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_id == ID_W'(i) && !src_enable[i] && !act_out[i])
      |=> !act_out[i]); // R8

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr[i] && src_is_edge[i]) |=> !src_state[i][0]); // R9

    AST_STRAY_DEACT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (deact_valid && deact_id == ID_W'(i) && !act_out[i] && !ack_taken[i])
      |=> !act_out[i]); // R10
  end

endmodule

bind irq_pend_store irq_pend_store_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_line    (src_line),
  .src_enable  (src_enable),
  .src_is_edge (src_is_edge),
  .src_no_act  (src_no_act),
  .sw_set      (sw_set),
  .sw_clr      (sw_clr),
  .ack_valid   (ack_valid),
  .ack_id      (ack_id),
  .deact_valid (deact_valid),
  .deact_id    (deact_id),
  .pend_out    (pend_out),
  .act_out     (act_out),
  .edge_evt    (edge_evt),
  .ack_taken   (ack_taken),
  .src_state   (src_state)
);

// File: tb/irq_pend_store_bench.sv
module irq_pend_store_bench;

  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_line = '0;
  logic [N-1:0]  src_enable = '1;
  // sources 1, 2, 4 edge; others level
  logic [N-1:0]  src_is_edge = 8'b0001_0110;
  // source 2 has no active state
  logic [N-1:0]  src_no_act = 8'b0000_0100;
  logic [N-1:0]  sw_set = '0;
  logic [N-1:0]  sw_clr = '0;
  logic          ack_valid = 1'b0;
  logic [IW-1:0] ack_id = '0;
  logic          deact_valid = 1'b0;
  logic [IW-1:0] deact_id = '0;
  logic [N-1:0]  pend_out;
  logic [N-1:0]  act_out;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_pend_store #(.NUM_SRC(N), .ID_W(IW)) u_irq_pend_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_line    (src_line),
    .src_enable  (src_enable),
    .src_is_edge (src_is_edge),
    .src_no_act  (src_no_act),
    .sw_set      (sw_set),
    .sw_clr      (sw_clr),
    .ack_valid   (ack_valid),
    .ack_id      (ack_id),
    .deact_valid (deact_valid),
    .deact_id    (deact_id),
    .pend_out    (pend_out),
    .act_out     (act_out)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  // check {active, pending} of one source
  task automatic chk_st(input string tag, input int i, input logic a, input logic p);
    chk({tag, " act"}, act_out[i], a);
    chk({tag, " pend"}, pend_out[i], p);
  endtask

  task automatic do_ack(input int i);
    ack_valid = 1'b1; ack_id = IW'(i);
    step();
    ack_valid = 1'b0;
  endtask

  task automatic do_deact(input int i);
    deact_valid = 1'b1; deact_id = IW'(i);
    step();
    deact_valid = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++) chk_st("R1 reset", i, 1'b0, 1'b0);
  endtask

  task automatic t_level();
    src_line[0] = 1'b1; step();
    chk_st("R2 level pend", 0, 1'b0, 1'b1);
    do_ack(0);
    chk_st("R3 level ack both", 0, 1'b1, 1'b1);
    src_line[0] = 1'b0; step();
    chk_st("R3 level line low", 0, 1'b1, 1'b0);
    do_deact(0);
    chk_st("R6 deact to idle", 0, 1'b0, 1'b0);
  endtask

  task automatic t_edge();
    src_line[1] = 1'b1; step();
    chk_st("R4 edge pend", 1, 1'b0, 1'b1);
    step();
    chk_st("R4 held line", 1, 1'b0, 1'b1);
    do_ack(1);
    chk_st("R4 edge ack", 1, 1'b1, 1'b0);
    do_ack(1);
    chk_st("R10 ack on active", 1, 1'b1, 1'b0);
    src_line[1] = 1'b0; step();
    src_line[1] = 1'b1; step();
    chk_st("R5 edge while active", 1, 1'b1, 1'b1);
    do_deact(1);
    chk_st("R6 deact to pend", 1, 1'b0, 1'b1);
    do_ack(1);
    do_deact(1);
    chk_st("R6 back to idle", 1, 1'b0, 1'b0);
    // absorbed edge
    src_line[1] = 1'b0; step();
    src_line[1] = 1'b1; step();
    src_line[1] = 1'b0; step();
    src_line[1] = 1'b1; step();
    chk_st("R5 second edge", 1, 1'b0, 1'b1);
    src_line[1] = 1'b0;
    do_ack(1);
    chk_st("R5 absorbed", 1, 1'b1, 1'b0);
    do_deact(1);
    chk_st("R5 idle after", 1, 1'b0, 1'b0);
  endtask

  task automatic t_no_act();
    src_line[2] = 1'b1; step();
    chk_st("R7 pend", 2, 1'b0, 1'b1);
    do_ack(2);
    chk_st("R7 ack to idle", 2, 1'b0, 1'b0);
    src_line[2] = 1'b0; step();
  endtask

  task automatic t_disable();
    src_enable[3] = 1'b0; src_line[3] = 1'b1; step();
    chk_st("R8 masked", 3, 1'b0, 1'b0);
    do_ack(3);
    chk_st("R8 ack ignored", 3, 1'b0, 1'b0);
    src_enable[3] = 1'b1; src_line[3] = 1'b0; #1;
    chk("R8 state kept", pend_out[3], 1'b1);
    step();
    chk_st("R8 line low", 3, 1'b0, 1'b0);
  endtask

  task automatic t_sw();
    sw_set[4] = 1'b1; step(); sw_set[4] = 1'b0;
    chk_st("R9 set", 4, 1'b0, 1'b1);
    sw_clr[4] = 1'b1; step(); sw_clr[4] = 1'b0;
    chk_st("R9 clr", 4, 1'b0, 1'b0);
    sw_set[4] = 1'b1; step();
    chk_st("R9 set again", 4, 1'b0, 1'b1);
    sw_clr[4] = 1'b1; step(); sw_set[4] = 1'b0; sw_clr[4] = 1'b0;
    chk_st("R9 clear wins", 4, 1'b0, 1'b0);
    sw_set[5] = 1'b1; step(); sw_set[5] = 1'b0;
    step();
    chk_st("R9 level sw held", 5, 1'b0, 1'b1);
    do_ack(5);
    chk_st("R9 ack consumes sw", 5, 1'b1, 1'b0);
    do_deact(5);
    chk_st("R9 idle", 5, 1'b0, 1'b0);
  endtask

  task automatic t_stray();
    do_deact(6);
    chk_st("R10 stray deact", 6, 1'b0, 1'b0);
    do_ack(6);
    chk_st("R10 stray ack", 6, 1'b0, 1'b0);
    for (int i = 0; i < N; i++) chk_st("R10 others idle", i, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_level();
    t_edge();
    t_no_act();
    t_disable();
    t_sw();
    t_stray();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule